// File: doc/BRIEF.md
# Majority-Vote Oversampled UART Receiver

This block receives asynchronous serial characters on a single line that rests at its idle level until a sender starts talking. A falling edge on the line, taken after a two-flop synchroniser and an optional polarity flip, starts a sub-bit timer. The timer samples the line three times per bit period, once in the middle of each third of the bit. Each bit is the 2-of-3 majority of its samples, so a short disturbance on the line does not corrupt a character.

A frame has a start bit, eight data bits sent least significant bit first, and a stop bit. A start bit that votes high is treated as noise and discarded. The stop bit is judged on its first two samples. After the second of these, the receiver goes back to hunting for a start edge, so a sender with a slightly fast clock or a short stop bit can follow directly with its next character. Each character goes into a small FIFO together with a framing-error flag, and a one-cycle strobe marks it. When the FIFO fills, the receiver stops until a flush clears the buffer and arms it again.

Top module: `vote_uart_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits with bit 0 sent first, and one high stop bit, with levels taken after polarity correction. The data bits appear unchanged on `out_data`.
- R2: The line is sampled every SUB_TICKS clock cycles. The first sample falls about SUB_TICKS/2 cycles after the start edge, so each sample lands in the middle of a third of a bit. A disturbance that stays inside one third of a bit changes no data.
- R3: A bit is received as 1 exactly when at least two of its three samples are 1. Two low thirds in a high bit give 0, and two high thirds in a low bit give 1.
- R4: If the start bit votes 1, the frame is dropped: no strobe, nothing stored. The receiver then waits for the next start edge.
- R5: Every stored character gives exactly one single-cycle `char_stb` pulse. The pulse comes just after the second stop-bit sample, and `out_valid` is high while it is asserted.
- R6: `out_ferr` is 1 unless both stop-bit samples are 1. The character is stored either way.
- R7: After the second stop-bit sample the receiver hunts for a start edge again. Frames sent back to back are received, and so are frames whose stop bit lasts only two thirds of a bit.
- R8: Up to DEPTH characters are held in arrival order and read out over `out_valid`/`out_ready`. `fill_count` gives the number held and never exceeds DEPTH.
- R9: Once the buffer holds DEPTH characters, reception stops. Later frames are ignored until `flush`, even if the buffer has been read out in the meantime.
- R10: `flush` empties the buffer in the next cycle, aborts any frame in progress and re-arms reception.
- R11: With `invert` at 1, the line is inverted: it idles low, and a start bit is high.
- R12: After reset, `out_valid`, `char_stb` and `fill_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input |
| invert | input | 1 | 1 selects inverted line polarity |
| flush | input | 1 | Clears the buffer and re-arms reception |
| char_stb | output | 1 | One-cycle pulse per stored character |
| out_valid | output | 1 | Buffer head holds a character |
| out_ready | input | 1 | Consumer takes the head character |
| out_data | output | 8 | Head character data |
| out_ferr | output | 1 | Head character framing error |
| fill_count | output | $clog2(DEPTH+1) | Characters held |

## Verification
The bench builds the block with SUB_TICKS = 6 and DEPTH = 4. An 18-cycle bit makes each third six cycles long, so the stimulus can flip single thirds of a bit. That is enough to reach both voting outcomes, the false-start path, a stop bit with one bad third, and a stop bit cut short to two thirds. The four-entry buffer fills after four frames, so the halt, the partial read-out while halted, and recovery by flush all fit in a short run. A second reset with inversion on repeats reception on the inverted line.

// File: rtl/vurx_pkg.sv
// Package: shared constants and types for the voting UART receiver.
// Assumes a fixed 10-bit frame (start, 8 data, stop) and three samples per bit.
package vurx_pkg;
    localparam int DATA_BITS     = 8;
    localparam int FRAME_BITS    = DATA_BITS + 2;
    localparam int STOP_BIT_IDX  = FRAME_BITS - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic                 ferr;
        logic [DATA_BITS-1:0] data;
    } rx_char_t;
endpackage

// File: rtl/vurx_line_front.sv
// Line front end: synchronises the raw serial input, applies the polarity
// option and flags a high-to-low transition of the corrected level.
// Assumes SYNC_STAGES >= 2 and that invert is changed only while idle or in reset.
module vurx_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    input  logic invert,
    output logic line_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], rx_raw};
    end

    // Corrected level: idle is always 1 after this point.
    assign line_o = chain_q[SYNC_STAGES-1] ^ invert;

    // Remember the previous corrected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_o;
    end

    assign fall_o = prev_q & ~line_o;
endmodule

// File: rtl/vurx_framer.sv
// Frame engine: on a start edge it runs a sub-bit timer and takes three samples
// per bit at the centres of the bit thirds. It votes each bit, drops false
// starts, checks the stop bit on its first two samples and emits one character.
// It goes back to idle after the second stop sample, and halts while full_i is
// set until flushed. Assumes SUB_TICKS >= 2.
module vurx_framer
    import vurx_pkg::*;
#(
    parameter int SUB_TICKS = 362
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    input  logic     fall_i,
    input  logic     flush_i,
    input  logic     full_i,
    output logic     push_o,
    output rx_char_t char_o
);
    localparam int TW   = (SUB_TICKS > 2) ? $clog2(SUB_TICKS) : 1;
    localparam int HALF = SUB_TICKS / 2;
    localparam int BW   = $clog2(FRAME_BITS);

    rx_state_e            state_q;
    logic [TW-1:0]        tcnt_q;
    logic [1:0]           phase_q;
    logic [BW-1:0]        bit_q;
    logic [1:0]           win_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 push_q;
    rx_char_t             char_q;
    logic                 vote;

    // Majority of the two held samples and the sample being taken now.
    assign vote = (win_q[0] & win_q[1]) | (win_q[0] & line_i) | (win_q[1] & line_i);

    // Sequence the frame: arm, time the samples, vote, assemble, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            phase_q <= '0;
            bit_q   <= '0;
            win_q   <= '0;
            shift_q <= '0;
            push_q  <= 1'b0;
            char_q  <= '0;
        end else begin
            push_q <= 1'b0;
            if (flush_i) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (full_i) begin
                            state_q <= ST_HALT;
                        end else if (fall_i) begin
                            state_q <= ST_RUN;
                            tcnt_q  <= TW'(HALF - 1);
                            phase_q <= 2'd0;
                            bit_q   <= '0;
                        end
                    end
                    ST_RUN: begin
                        if (tcnt_q != '0) begin
                            tcnt_q <= tcnt_q - 1'b1;
                        end else begin
                            tcnt_q <= TW'(SUB_TICKS - 1);
                            case (phase_q)
                                2'd0: begin
                                    win_q[0] <= line_i;
                                    phase_q  <= 2'd1;
                                end
                                2'd1: begin
                                    win_q[1] <= line_i;
                                    phase_q  <= 2'd2;
                                    if (bit_q == BW'(STOP_BIT_IDX)) begin
                                        push_q      <= 1'b1;
                                        char_q.ferr <= ~(win_q[0] & line_i);
                                        char_q.data <= shift_q;
                                        state_q     <= ST_IDLE;
                                    end
                                end
                                default: begin
                                    phase_q <= 2'd0;
                                    bit_q   <= bit_q + 1'b1;
                                    if (bit_q == '0) begin
                                        if (vote) state_q <= ST_IDLE;
                                    end else begin
                                        shift_q <= {vote, shift_q[DATA_BITS-1:1]};
                                    end
                                end
                            endcase
                        end
                    end
                    default: state_q <= ST_HALT;
                endcase
            end
        end
    end

    assign push_o = push_q;
    assign char_o = char_q;
endmodule

// File: rtl/vurx_fifo.sv
// Character buffer: DEPTH-entry first-in first-out store with a valid/ready read
// side and a synchronous flush. Pushes into a full buffer are dropped.
// Assumes DEPTH >= 2.
module vurx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  logic [WIDTH-1:0]           din_i,
    input  logic                       pop_i,
    output logic [WIDTH-1:0]           dout_o,
    output logic                       valid_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    count_q;
    logic             do_push, do_pop;

    assign do_push = push_i && (count_q != CW'(DEPTH));
    assign do_pop  = pop_i && (count_q != '0);

    // Write the incoming character into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem_q[wptr_q] <= din_i;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign dout_o  = mem_q[rptr_q];
    assign valid_o = (count_q != '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign count_o = count_q;
endmodule

// File: rtl/vote_uart_rx.sv
// Top: voting oversampled UART receiver. Connects the line front end, the
// frame engine and the character buffer, and registers the character strobe
// in step with the buffer write. Assumes SUB_TICKS = round(f_clk / (3 * baud)).
module vote_uart_rx
    import vurx_pkg::*;
#(
    parameter int SUB_TICKS = 362,
    parameter int DEPTH     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_line,
    input  logic                       invert,
    input  logic                       flush,
    output logic                       char_stb,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_BITS-1:0]       out_data,
    output logic                       out_ferr,
    output logic [$clog2(DEPTH+1)-1:0] fill_count
);
    localparam int CHW = $bits(rx_char_t);

    logic     line_c, fall_c, push_c, full_c, stb_q;
    rx_char_t char_c, head_c;

    vurx_line_front #(.SYNC_STAGES(2)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (rx_line),
        .invert (invert),
        .line_o (line_c),
        .fall_o (fall_c)
    );

    vurx_framer #(.SUB_TICKS(SUB_TICKS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_c),
        .fall_i  (fall_c),
        .flush_i (flush),
        .full_i  (full_c),
        .push_o  (push_c),
        .char_o  (char_c)
    );

    vurx_fifo #(.WIDTH(CHW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push_c),
        .din_i   (char_c),
        .pop_i   (out_ready),
        .dout_o  (head_c),
        .valid_o (out_valid),
        .full_o  (full_c),
        .count_o (fill_count)
    );

    // Pulse the strobe in the cycle the stored character becomes visible.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= push_c && !flush && !full_c;
    end

    assign char_stb = stb_q;
    assign out_data = head_c.data;
    assign out_ferr = head_c.ferr;
endmodule

// File: rtl/vote_uart_rx_checker.sv
// Checker: port-level properties of the voting UART receiver, bound to the top.
module vote_uart_rx_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       char_stb,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [$clog2(DEPTH+1)-1:0] fill_count
);
    // R8: occupancy never exceeds the buffer depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= ($clog2(DEPTH+1))'(DEPTH));

    // R5: the strobe lasts a single cycle.
    a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |=> !char_stb);

    // R5: a strobe always coincides with a readable character.
    a_r5_stb_stored: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |-> out_valid);

    // R9: a full buffer that is neither read nor flushed stays full.
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == ($clog2(DEPTH+1))'(DEPTH) && !out_ready && !flush)
        |=> fill_count == ($clog2(DEPTH+1))'(DEPTH));

    // R10: a flush leaves the buffer empty in the next cycle.
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_count == '0 && !out_valid));
endmodule

bind vote_uart_rx vote_uart_rx_checker #(.DEPTH(DEPTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .char_stb   (char_stb),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .fill_count (fill_count)
);

// File: tb/vote_uart_rx_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected characters, the monitor pops and
// compares every character read from the buffer.
module vote_uart_rx_bench;
    localparam int SUB   = 6;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b1;
    logic          invert = 1'b0;
    logic          flush = 1'b0;
    logic          rd_en = 1'b1;
    logic          char_stb, out_valid, out_ferr;
    logic [7:0]    out_data;
    logic [CW-1:0] fill_count;

    int   errors = 0;
    int   checks = 0;
    int   stb_seen = 0;
    int   stb_exp = 0;
    logic stb_prev = 1'b0;
    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    vote_uart_rx #(.SUB_TICKS(SUB), .DEPTH(DEPTH)) u_vote_uart_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .invert(invert), .flush(flush),
        .char_stb(char_stb), .out_valid(out_valid), .out_ready(rd_en),
        .out_data(out_data), .out_ferr(out_ferr), .fill_count(fill_count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: count strobes and compare every character read out.
    always @(negedge clk) begin
        if (rst_n) begin
            if (char_stb) begin
                stb_seen++;
                if (stb_prev) chk(1'b0, "R5 strobe longer than one cycle", 1, 0);
            end
            stb_prev = char_stb;
            if (out_valid && rd_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected character", {out_ferr, out_data}, 0);
                end else begin
                    logic [8:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e[7:0], {t, " data"}, out_data, e[7:0]);
                    chk(out_ferr == e[8], {"R6 ferr / ", t}, out_ferr, e[8]);
                end
            end
        end
    end

    function automatic logic [29:0] frame(input logic [7:0] d, input bit stop_ok);
        logic [29:0] th;
        th = '0;
        for (int j = 0; j < 8; j++) th[3+3*j +: 3] = {3{d[j]}};
        th[27 +: 3] = stop_ok ? 3'b111 : 3'b000;
        return th;
    endfunction

    task automatic send_thirds(input logic [29:0] th, input int n);
        for (int i = 0; i < n; i++) begin
            rx_line = th[i] ^ invert;
            repeat (SUB) @(posedge clk);
            #1;
        end
    endtask

    task automatic idle(input int n);
        rx_line = ~invert;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_char(input logic [7:0] d, input logic ferr, input string tag);
        exp_q.push_back({ferr, d});
        tag_q.push_back(tag);
        stb_exp++;
    endtask

    task automatic send_char(input logic [29:0] th, input bit exp, input logic [7:0] d,
                             input logic ferr, input string tag);
        if (exp) expect_char(d, ferr, tag);
        send_thirds(th, 30);
        idle(24);
    endtask

    task automatic do_reset(input logic inv);
        rst_n = 1'b0;
        invert = inv;
        rx_line = ~inv;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        chk(out_valid == 1'b0, "R12 out_valid after reset", out_valid, 0);
        chk(char_stb == 1'b0, "R12 char_stb after reset", char_stb, 0);
        chk(fill_count == '0, "R12 fill_count after reset", fill_count, 0);
        @(posedge clk);
        #1;
        idle(10);
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [29:0] th;
        int s0;
        @(posedge clk);
        #1;
        do_reset(1'b0);

        // R1: plain characters
        send_char(frame(8'h55, 1), 1, 8'h55, 1'b0, "R1 0x55");
        send_char(frame(8'hA3, 1), 1, 8'hA3, 1'b0, "R1 0xA3");
        send_char(frame(8'h00, 1), 1, 8'h00, 1'b0, "R1 0x00");
        send_char(frame(8'hFF, 1), 1, 8'hFF, 1'b0, "R1 0xFF");

        // R2: single-third disturbances leave the data intact
        th = frame(8'hA5, 1);
        th[4]  = ~th[4];
        th[14] = ~th[14];
        th[26] = ~th[26];
        send_char(th, 1, 8'hA5, 1'b0, "R2 one-third glitches");

        // R3: two flipped thirds change the bit
        th = frame(8'h0F, 1);
        th[6] = 1'b0; th[7] = 1'b0;
        th[18] = 1'b1; th[19] = 1'b1;
        send_char(th, 1, 8'h2D, 1'b0, "R3 two-of-three vote");

        // R4: a start bit low for one third is dropped
        s0 = stb_seen;
        th = '1;
        th[0] = 1'b0;
        send_thirds(th, 30);
        idle(24);
        chk(stb_seen == s0, "R4 false start strobe", stb_seen, s0);
        chk(fill_count == '0, "R4 false start stored", fill_count, 0);
        send_char(frame(8'h7E, 1), 1, 8'h7E, 1'b0, "R4 after false start");

        // R6: bad stop bit, full and single third
        send_char(frame(8'h81, 0), 1, 8'h81, 1'b1, "R6 stop low");
        th = frame(8'h42, 1);
        th[27] = 1'b0;
        send_char(th, 1, 8'h42, 1'b1, "R6 stop first third low");
        th = frame(8'h24, 1);
        th[29] = 1'b0;
        send_char(th, 1, 8'h24, 1'b0, "R6 stop last third ignored");

        // R7: back to back, and a stop bit cut to two thirds
        expect_char(8'h11, 1'b0, "R7 back-to-back first");
        expect_char(8'h22, 1'b0, "R7 back-to-back second");
        send_thirds(frame(8'h11, 1), 30);
        send_thirds(frame(8'h22, 1), 30);
        idle(24);
        expect_char(8'h33, 1'b0, "R7 short stop first");
        expect_char(8'h44, 1'b0, "R7 short stop second");
        send_thirds(frame(8'h33, 1), 29);
        send_thirds(frame(8'h44, 1), 30);
        idle(24);
        chk(stb_seen == stb_exp, "R5 strobe count", stb_seen, stb_exp);

        // R9: fill the buffer, then reception halts
        rd_en = 1'b0;
        send_char(frame(8'hC1, 1), 1, 8'hC1, 1'b0, "R8 order 1");
        send_char(frame(8'hC2, 1), 1, 8'hC2, 1'b0, "R8 order 2");
        send_char(frame(8'hC3, 1), 1, 8'hC3, 1'b0, "R8 order 3");
        send_char(frame(8'hC4, 1), 1, 8'hC4, 1'b0, "R8 order 4");
        chk(fill_count == CW'(DEPTH), "R8 fill count full", fill_count, DEPTH);
        send_char(frame(8'hEE, 1), 0, 8'h00, 1'b0, "");
        chk(fill_count == CW'(DEPTH), "R9 frame while full", fill_count, DEPTH);
        rd_en = 1'b1;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        send_char(frame(8'hED, 1), 0, 8'h00, 1'b0, "");
        chk(fill_count == CW'(DEPTH - 1), "R9 halted after partial read", fill_count, DEPTH - 1);
        chk(stb_seen == stb_exp, "R9 no strobe while halted", stb_seen, stb_exp);
        rd_en = 1'b1;
        idle(10);
        chk(fill_count == '0, "R8 drained", fill_count, 0);

        // R10: flush discards stored characters and re-arms
        pulse_flush();
        rd_en = 1'b0;
        stb_exp += 2;
        send_char(frame(8'h91, 1), 0, 8'h00, 1'b0, "");
        send_char(frame(8'h92, 1), 0, 8'h00, 1'b0, "");
        chk(fill_count == CW'(2), "R10 count before flush", fill_count, 2);
        pulse_flush();
        chk(fill_count == '0, "R10 count after flush", fill_count, 0);
        chk(out_valid == 1'b0, "R10 valid after flush", out_valid, 0);
        rd_en = 1'b1;
        send_char(frame(8'h5A, 1), 1, 8'h5A, 1'b0, "R10 re-armed");

        // R11: inverted line polarity
        do_reset(1'b1);
        send_char(frame(8'hC6, 1), 1, 8'hC6, 1'b0, "R11 inverted 0xC6");
        send_char(frame(8'h01, 1), 1, 8'h01, 1'b0, "R11 inverted 0x01");

        idle(20);
        chk(exp_q.size() == 0, "R8 all expected characters read", exp_q.size(), 0);
        chk(stb_seen == stb_exp, "R5 final strobe count", stb_seen, stb_exp);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule